// File: doc/BRIEF.md
# Integer Execution Unit with Condition Flag

This block is the 32-bit integer execution stage of a small control processor. Each cycle it may accept one operation: an opcode plus up to three register operands (`in_a`, `in_b`, `in_c`). One cycle later it presents either a data result, a single condition flag, or both. Each result comes with write-enable qualifiers that tell the surrounding pipeline what to write back. The register file, multiply, divide and program-counter logic sit outside the block.

The operation set covers two- and three-operand add and subtract, six bitwise functions including their inverted forms, and three shift-class operations. The shift class is arithmetic shift, logical shift and rotate, each steered by a signed amount. It also covers six signed relational compares and a fused operation. The fused operation adds `in_a` and `in_b`, returns the sum for write-back to the first register, and at the same time raises the flag when that sum exceeds `in_c`. A shift amount outside the legal window raises an error output in place of a trustworthy result.

Top module: `int_exec_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. The outputs then carry the result of the operation accepted on that edge.
- R2: Opcode 0 returns `in_a + in_b` and opcode 1 returns `in_a - in_b`. Both wrap modulo 2^32.
- R3: Opcode 2 returns `in_a + in_b + in_c` and opcode 3 returns `in_a + in_b - in_c`. Both wrap modulo 2^32.
- R4: Opcodes 4 to 9 return, in that order, the bitwise AND, OR, XOR, NAND, NOR and XNOR of `in_a` and `in_b`.
- R5: Opcodes 10 (arithmetic), 11 (logical) and 12 (rotate) move `in_a` by the signed amount in `in_b`. A positive amount moves left and a negative amount moves right by its magnitude. An amount of zero returns `in_a` unchanged. Right arithmetic shifts fill with bit 31, right logical shifts fill with zero, and rotation is circular in both directions.
- R6: For opcodes 10 to 12, `out_shift_err` is 1 exactly when the signed amount lies outside -31..31, and the data result is then undefined. For every other opcode `out_shift_err` is 0.
- R7: Opcodes 13 to 18 (EQ, NE, GT, LT, GE, LE) compare `in_a` with `in_b` as signed two's complement. They set `out_flag` to 1 when the relation holds and to 0 otherwise, with `out_flag_we`=1, `out_res_we`=0 and `out_result`=0.
- R8: Opcode 19 returns the wrapped sum `in_a + in_b` with `out_res_we`=1. It also sets `out_flag` to 1 exactly when that wrapped sum, read as signed, is greater than signed `in_c`, with `out_flag_we`=1.
- R9: Opcodes 0 to 12 give `out_res_we`=1, `out_flag_we`=0 and `out_flag`=0. Opcodes 20 to 31 give a result of 0 with both write enables, the flag and the error all 0.
- R10: While `in_valid` is low, `out_result`, `out_flag`, `out_res_we`, `out_flag_we` and `out_shift_err` keep the values of the last accepted operation, whatever the operand inputs do.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 5 | Opcode |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand, and the signed amount for the shift class |
| in_c | input | 32 | Third operand |
| out_valid | output | 1 | Result of last cycle's operation present |
| out_result | output | 32 | Data result |
| out_flag | output | 1 | Condition flag |
| out_res_we | output | 1 | Data result is to be written back |
| out_flag_we | output | 1 | Flag is to be written |
| out_shift_err | output | 1 | Shift amount out of range |

## Verification
The hardest cases to reach from the ports are the edges of the shift window. At the edge, amounts of ±31 must still shift correctly while ±32 must raise the error. The same edge matters for the most negative amount 0x80000000, whose magnitude cannot be negated inside 32 bits. The stimulus drives each of these values into all three shift opcodes. It also covers the fused add-and-compare when `in_a + in_b` overflows, so that the flag must follow the wrapped sum rather than the true sum. Back-to-back valid operations and idle gaps with changing operands are interleaved to exercise the hold behaviour.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD     = 5'd0,
        OP_SUB     = 5'd1,
        OP_ADD3    = 5'd2,
        OP_ADDSUB3 = 5'd3,
        OP_AND     = 5'd4,
        OP_OR      = 5'd5,
        OP_XOR     = 5'd6,
        OP_NAND    = 5'd7,
        OP_NOR     = 5'd8,
        OP_XNOR    = 5'd9,
        OP_ASH     = 5'd10,
        OP_LSH     = 5'd11,
        OP_ROT     = 5'd12,
        OP_EQ      = 5'd13,
        OP_NE      = 5'd14,
        OP_GT      = 5'd15,
        OP_LT      = 5'd16,
        OP_GE      = 5'd17,
        OP_LE      = 5'd18,
        OP_INCCMP  = 5'd19
    } op_e;

    function automatic logic is_shift_op(input logic [OP_W-1:0] op);
        return (op == OP_ASH) || (op == OP_LSH) || (op == OP_ROT);
    endfunction

endpackage

// File: rtl/iexu_addsub.sv
module iexu_addsub
    import iexu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum_ab,
    output logic [W-1:0] y
);
    // a+b is shared by the plain add, the three-operand forms and the fused op
    always_comb begin
        sum_ab = a + b;
        unique case (op)
            OP_SUB:     y = a - b;
            OP_ADD3:    y = sum_ab + c;
            OP_ADDSUB3: y = sum_ab - c;
            default:    y = sum_ab;
        endcase
    end
endmodule

// File: rtl/iexu_logic.sv
module iexu_logic
    import iexu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] core_d;
    logic         invert_d;

    always_comb begin
        invert_d = 1'b0;
        unique case (op)
            OP_OR, OP_NOR:   core_d = a | b;
            OP_XOR, OP_XNOR: core_d = a ^ b;
            default:         core_d = a & b;
        endcase
        if (op == OP_NAND || op == OP_NOR || op == OP_XNOR) begin
            invert_d = 1'b1;
        end
        y = invert_d ? ~core_d : core_d;
    end
endmodule

// File: rtl/iexu_shift.sv
module iexu_shift
    import iexu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] amt,
    output logic [W-1:0] y,
    output logic         err
);
    localparam logic [W-1:0] WIDTH_V = W[W-1:0];

    logic         right_d;
    logic [W-1:0] mag_d;
    logic [W-1:0] left_d;
    logic [W-1:0] lsr_d;
    logic [W-1:0] asr_d;
    logic [W-1:0] rol_d;
    logic [W-1:0] ror_d;

    always_comb begin
        right_d = amt[W-1];
        mag_d   = right_d ? (~amt + 1'b1) : amt;
        err     = !(($signed(amt) > -W) && ($signed(amt) < W));
        left_d  = a << mag_d;
        lsr_d   = a >> mag_d;
        asr_d   = $signed(a) >>> mag_d;
        rol_d   = left_d | (a >> (WIDTH_V - mag_d));
        ror_d   = lsr_d  | (a << (WIDTH_V - mag_d));
        unique case (op)
            OP_ASH:  y = right_d ? asr_d : left_d;
            OP_ROT:  y = right_d ? ror_d : rol_d;
            default: y = right_d ? lsr_d : left_d;
        endcase
    end
endmodule

// File: rtl/iexu_cmp.sv
module iexu_cmp
    import iexu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] sum_ab,
    output logic         flag
);
    logic eq_d;
    logic gt_d;

    always_comb begin
        eq_d = (a == b);
        gt_d = ($signed(a) > $signed(b));
        unique case (op)
            OP_EQ:     flag = eq_d;
            OP_NE:     flag = !eq_d;
            OP_GT:     flag = gt_d;
            OP_LT:     flag = !gt_d && !eq_d;
            OP_GE:     flag = gt_d || eq_d;
            OP_LE:     flag = !gt_d;
            OP_INCCMP: flag = ($signed(sum_ab) > $signed(c));
            default:   flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_c,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_flag,
    output logic              out_res_we,
    output logic              out_flag_we,
    output logic              out_shift_err
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic              flag;
        logic              res_we;
        logic              flag_we;
        logic              err;
    } stage_t;

    stage_t stage_d, stage_q;

    op_e               op_w;
    logic [DATA_W-1:0] sum_ab_w;
    logic [DATA_W-1:0] arith_w;
    logic [DATA_W-1:0] logic_w;
    logic [DATA_W-1:0] shift_w;
    logic              shift_err_w;
    logic              cmp_flag_w;

    assign op_w = op_e'(in_op);

    iexu_addsub #(.W(DATA_W)) u_addsub (
        .op(op_w), .a(in_a), .b(in_b), .c(in_c), .sum_ab(sum_ab_w), .y(arith_w)
    );

    iexu_logic #(.W(DATA_W)) u_logic (
        .op(op_w), .a(in_a), .b(in_b), .y(logic_w)
    );

    iexu_shift #(.W(DATA_W)) u_shift (
        .op(op_w), .a(in_a), .amt(in_b), .y(shift_w), .err(shift_err_w)
    );

    iexu_cmp #(.W(DATA_W)) u_cmp (
        .op(op_w), .a(in_a), .b(in_b), .c(in_c), .sum_ab(sum_ab_w), .flag(cmp_flag_w)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.result  = '0;
            stage_d.flag    = 1'b0;
            stage_d.res_we  = 1'b0;
            stage_d.flag_we = 1'b0;
            stage_d.err     = 1'b0;
            unique case (op_w)
                OP_ADD, OP_SUB, OP_ADD3, OP_ADDSUB3: begin
                    stage_d.result = arith_w;
                    stage_d.res_we = 1'b1;
                end
                OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOR, OP_XNOR: begin
                    stage_d.result = logic_w;
                    stage_d.res_we = 1'b1;
                end
                OP_ASH, OP_LSH, OP_ROT: begin
                    stage_d.result = shift_w;
                    stage_d.res_we = 1'b1;
                    stage_d.err    = shift_err_w;
                end
                OP_EQ, OP_NE, OP_GT, OP_LT, OP_GE, OP_LE: begin
                    stage_d.flag    = cmp_flag_w;
                    stage_d.flag_we = 1'b1;
                end
                OP_INCCMP: begin
                    stage_d.result  = sum_ab_w;
                    stage_d.res_we  = 1'b1;
                    stage_d.flag    = cmp_flag_w;
                    stage_d.flag_we = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid     = stage_q.valid;
    assign out_result    = stage_q.result;
    assign out_flag      = stage_q.flag;
    assign out_res_we    = stage_q.res_we;
    assign out_flag_we   = stage_q.flag_we;
    assign out_shift_err = stage_q.err;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_flag) && $stable(out_shift_err)));
    // R9
    flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_flag_we |-> !out_flag);
    // R6
    err_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_shift_err |-> (out_res_we && !out_flag_we));
    // R5
    zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift_op(in_op) && in_b == '0) |=> (out_result == $past(in_a)));
    // R8
    fused_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_INCCMP) |=> (out_res_we && out_flag_we));
    // R7
    cmp_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= OP_EQ && in_op <= OP_LE) |=> (!out_res_we && out_result == '0));
endmodule

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;

    typedef struct {
        logic [31:0] res;
        logic        flag;
        logic        res_we;
        logic        flag_we;
        logic        err;
        logic        cmp_res;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [31:0] in_a = '0, in_b = '0, in_c = '0;
    logic        out_valid, out_flag, out_res_we, out_flag_we, out_shift_err;
    logic [31:0] out_result;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    int_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .out_valid(out_valid),
        .out_result(out_result), .out_flag(out_flag), .out_res_we(out_res_we),
        .out_flag_we(out_flag_we), .out_shift_err(out_shift_err)
    );

    function automatic exp_t model(input logic [4:0] op, input logic [31:0] a,
                                   input logic [31:0] b, input logic [31:0] c);
        exp_t e;
        int   k;
        e.res = '0; e.flag = 0; e.res_we = 0; e.flag_we = 0; e.err = 0; e.cmp_res = 1;
        e.tag = "";
        if (op <= 12) e.res_we = 1;
        case (op)
            0: e.res = a + b;
            1: e.res = a + ~b + 32'd1;
            2: e.res = a + b + c;
            3: e.res = a + b + ~c + 32'd1;
            4: e.res = a & b;
            5: e.res = a | b;
            6: e.res = a ^ b;
            7: e.res = ~(a & b);
            8: e.res = ~(a | b);
            9: e.res = ~(a ^ b);
            10, 11, 12: begin
                k = $signed(b);
                if (k <= -32 || k >= 32) begin
                    e.err = 1; e.cmp_res = 0;
                end else begin
                    for (int j = 0; j < 32; j++) begin
                        if (k >= 0) begin
                            if (op == 12) e.res[j] = a[(j - k + 32) % 32];
                            else          e.res[j] = (j - k >= 0) ? a[j - k] : 1'b0;
                        end else begin
                            if (op == 12)          e.res[j] = a[(j - k) % 32];
                            else if (j - k < 32)   e.res[j] = a[j - k];
                            else                   e.res[j] = (op == 10) ? a[31] : 1'b0;
                        end
                    end
                end
            end
            13: begin e.flag_we = 1; e.flag = (a == b); end
            14: begin e.flag_we = 1; e.flag = (a != b); end
            15: begin e.flag_we = 1; e.flag = ($signed(a) >  $signed(b)); end
            16: begin e.flag_we = 1; e.flag = ($signed(a) <  $signed(b)); end
            17: begin e.flag_we = 1; e.flag = ($signed(a) >= $signed(b)); end
            18: begin e.flag_we = 1; e.flag = ($signed(a) <= $signed(b)); end
            19: begin
                e.res = a + b; e.res_we = 1; e.flag_we = 1;
                e.flag = ($signed(e.res) > $signed(c));
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_c = c;
        e = model(op, a, b, c);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_a = in_a ^ 32'h5A5A_1234; in_b = in_b + 32'd7; in_op = in_op + 5'd1;
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // monitor: sample 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check((!e.cmp_res || out_result == e.res) && out_flag == e.flag &&
                      out_res_we == e.res_we && out_flag_we == e.flag_we &&
                      out_shift_err == e.err, e.tag, "result/flag/we/err",
                      {out_result[27:0], out_flag, out_res_we, out_flag_we, out_shift_err},
                      {e.res[27:0], e.flag, e.res_we, e.flag_we, e.err});
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        logic        held_f;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(out_valid == 0 && out_result == 0 && out_flag == 0 && out_res_we == 0 &&
              out_flag_we == 0 && out_shift_err == 0, "R11", "reset outputs",
              out_result, 32'd0);
        rst_n = 1'b1;
        idle(1);
        // R2
        drive(0, 32'h7FFF_FFFF, 32'd1, 0, "R2");
        drive(0, 32'hFFFF_FFFF, 32'd2, 0, "R2");
        drive(1, 32'd5, 32'd9, 0, "R2");
        // R3
        drive(2, 32'd10, 32'd20, 32'd30, "R3");
        drive(2, 32'hFFFF_FFF0, 32'd8, 32'd9, "R3");
        drive(3, 32'd10, 32'd20, 32'd35, "R3");
        // R4
        for (int op = 4; op <= 9; op++) drive(op[4:0], 32'hF0F0_CC33, 32'hFF00_A5A5, 0, "R4");
        // R5 / R6 shift window edges
        for (int op = 10; op <= 12; op++) begin
            drive(op[4:0], 32'h8000_00F1, 32'd0, 0, "R5");
            drive(op[4:0], 32'h8000_00F1, 32'd4, 0, "R5");
            drive(op[4:0], 32'h8000_00F1, -32'sd4, 0, "R5");
            drive(op[4:0], 32'hC000_0003, 32'd31, 0, "R5");
            drive(op[4:0], 32'hC000_0003, -32'sd31, 0, "R5");
            drive(op[4:0], 32'h1234_5678, 32'd32, 0, "R6");
            drive(op[4:0], 32'h1234_5678, -32'sd32, 0, "R6");
            drive(op[4:0], 32'h1234_5678, 32'h8000_0000, 0, "R6");
        end
        // R7 compares, signed
        for (int op = 13; op <= 18; op++) begin
            drive(op[4:0], 32'hFFFF_FFFF, 32'd1, 0, "R7");
            drive(op[4:0], 32'd1, 32'hFFFF_FFFF, 0, "R7");
            drive(op[4:0], 32'd42, 32'd42, 0, "R7");
        end
        // R8 fused add and compare, including wrap
        drive(19, 32'd3, 32'd4, 32'd6, "R8");
        drive(19, 32'd3, 32'd4, 32'd7, "R8");
        drive(19, 32'h7FFF_FFFF, 32'd1, 32'd0, "R8");
        drive(19, 32'hFFFF_FFFE, 32'd1, 32'hFFFF_FFFE, "R8");
        // R9 undefined opcodes clear everything
        drive(15, 32'd9, 32'd1, 0, "R7");
        drive(20, 32'd9, 32'd1, 0, "R9");
        drive(31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R9");
        drive(0, 32'd100, 32'd23, 0, "R1");
        // R10 hold while idle
        idle(1);
        @(posedge clk); #5;
        held = out_result; held_f = out_flag;
        idle(3);
        @(posedge clk); #5;
        check(out_valid == 0, "R1", "out_valid low when idle", {31'd0, out_valid}, 32'd0);
        check(out_result == held && out_result == 32'd123 && out_flag == held_f &&
              out_res_we == 1, "R10", "hold during idle", out_result, 32'd123);
        drive(13, 32'd7, 32'd7, 0, "R7");
        idle(2);
        @(posedge clk); #5;
        check(out_flag == 1 && out_flag_we == 1, "R10", "flag hold during idle",
              {31'd0, out_flag}, 32'd1);
        idle(2);
        check(sb_q.size() == 0, "R1", "all results returned", sb_q.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule